// File: doc/BRIEF.md
# Interrupt Line Event Collector

This block watches sixteen interrupt request lines and turns their changes into two pending masks: one that lists lines that need to be raised in a downstream interrupt controller, and one that lists lines that need to be lowered there. A per-line trigger-mode input decides the reporting rules for each line. A level-mode line reports both its rising and its falling transitions. An edge-mode line reports only new rising edges, and it remembers the last level it saw so that a line held high is reported once. Bits 7:0 of each mask serve the first (primary) controller and bits 15:8 serve the cascaded secondary one.

A consumer requests a drain with a one-cycle `drain_req`. A small state machine then presents the lowering mask in one cycle and the raising mask in the next. Each mask is zeroed as it is handed out. A registered `notify` pulse tells the consumer that new work has been recorded.

Drain states: `DR_IDLE` waits for a request (`DR_IDLE -> DR_CLR` on `drain_req`). `DR_CLR` presents and zeroes the lowering mask (`DR_CLR -> DR_SET` always). `DR_SET` presents and zeroes the raising mask (`DR_SET -> DR_IDLE` always). A request made while a drain is in progress is ignored.

Top module: `irq_event_collector`

## Requirements
- R1: Bit i of `trig_level` set to 1 selects level reporting for line i, and 0 selects edge reporting. A mixed setting gives each line its own rule.
- R2: A level-mode line that rises sets its raising bit and cancels its lowering bit. `notify` goes high in the cycle after the clock edge that samples the rise.
- R3: A level-mode line that falls sets its lowering bit and cancels its raising bit. `notify` goes high in the cycle after the clock edge that samples the fall.
- R4: An edge-mode line that rises while its last-level bit is 0 sets its raising bit and its last-level bit, and raises `notify`. Holding the line high records nothing more.
- R5: An edge-mode line that falls only clears its last-level bit. No mask bit changes and `notify` stays low.
- R6: A drain shows the lowering mask (`drain_is_set`=0) in the first cycle after the request and the raising mask (`drain_is_set`=1) in the next cycle, with `drain_valid` high in both cycles. Each mask reads as zero at the following drain unless new events have occurred.
- R7: Mask bit i maps to input line i. Bits 7:0 belong to primary inputs 0 to 7 and bits 15:8 to secondary inputs 0 to 7.
- R8: A synchronous active-high `rst` zeroes both masks, the last-level bits, `notify` and the drain state.
- R9: An event recorded at the same clock edge that zeroes its mask survives, and it is returned by the next drain.
- R10: `notify` is high for one cycle for each clock edge that records any event. Several simultaneous events produce a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Interrupt request lines, sampled each edge |
| trig_level | input | 16 | Per-line mode: 1 level, 0 edge |
| drain_req | input | 1 | One-cycle drain request |
| notify | output | 1 | One-cycle pulse: new events recorded |
| drain_valid | output | 1 | `drain_mask` holds a drained mask |
| drain_is_set | output | 1 | 0: lowering mask, 1: raising mask |
| drain_mask | output | 16 | Drained mask contents |

## Verification
The hardest case to reach is the collision: a new rising edge has to be sampled at exactly the clock edge that leaves `DR_SET` and zeroes the raising mask. The bench reaches it by running a drain cycle by cycle. It raises an edge-mode line at the falling edge of the `DR_SET` cycle, after reading the mask out, and then checks that a second drain returns that line. A second difficult case is a level line that rises and then falls before any drain. The bench creates it without a drain in between, so that the cancelling of the opposite bit can be seen.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_CLR  = 2'd1,
        DR_SET  = 2'd2
    } drain_st_e;
endpackage

// File: rtl/irq_evt_group.sv
module irq_evt_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    input  logic [W-1:0] lvl_mode,
    input  logic         zero_set,
    input  logic         zero_clr,
    output logic [W-1:0] pend_set,
    output logic [W-1:0] pend_clr,
    output logic         any_evt
);
    logic [W-1:0] last_lvl;
    logic [W-1:0] rise_w;
    logic [W-1:0] lvl_rise_w;
    logic [W-1:0] lvl_fall_w;
    logic [W-1:0] keep_set;
    logic [W-1:0] keep_clr;

    always_comb begin
        rise_w     = lines & ~last_lvl;
        lvl_rise_w = rise_w & lvl_mode;
        lvl_fall_w = ~lines & last_lvl & lvl_mode;
        keep_set   = zero_set ? '0 : pend_set;
        keep_clr   = zero_clr ? '0 : pend_clr;
        any_evt    = |(rise_w | lvl_fall_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_lvl <= '0;
            pend_set <= '0;
            pend_clr <= '0;
        end else begin
            last_lvl <= lines;
            pend_set <= (keep_set & ~lvl_fall_w) | rise_w;
            pend_clr <= (keep_clr & ~lvl_rise_w) | lvl_fall_w;
        end
    end
endmodule

// File: rtl/irq_drain_fsm.sv
module irq_drain_fsm
    import irqc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic         zero_set,
    output logic         zero_clr,
    output logic         valid,
    output logic         is_set,
    output logic [W-1:0] mask_out
);
    drain_st_e state_q;
    drain_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: if (req) state_d = DR_CLR;
            DR_CLR:  state_d = DR_SET;
            DR_SET:  state_d = DR_IDLE;
            default: state_d = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DR_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        zero_set = 1'b0;
        zero_clr = 1'b0;
        valid    = 1'b0;
        is_set   = 1'b0;
        mask_out = '0;
        unique case (state_q)
            DR_IDLE: ;
            DR_CLR: begin
                zero_clr = 1'b1;
                valid    = 1'b1;
                mask_out = clr_mask;
            end
            DR_SET: begin
                zero_set = 1'b1;
                valid    = 1'b1;
                is_set   = 1'b1;
                mask_out = set_mask;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_event_collector.sv
module irq_event_collector #(
    parameter int GROUP_W    = 8,
    parameter int NUM_GROUPS = 2,
    localparam int LINES     = GROUP_W * NUM_GROUPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_lines,
    input  logic [LINES-1:0] trig_level,
    input  logic             drain_req,
    output logic             notify,
    output logic             drain_valid,
    output logic             drain_is_set,
    output logic [LINES-1:0] drain_mask
);
    logic [LINES-1:0]      set_all;
    logic [LINES-1:0]      clr_all;
    logic [NUM_GROUPS-1:0] grp_evt;
    logic                  zero_set;
    logic                  zero_clr;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        irq_evt_group #(.W(GROUP_W)) u_grp (
            .clk      (clk),
            .rst      (rst),
            .lines    (irq_lines[g*GROUP_W +: GROUP_W]),
            .lvl_mode (trig_level[g*GROUP_W +: GROUP_W]),
            .zero_set (zero_set),
            .zero_clr (zero_clr),
            .pend_set (set_all[g*GROUP_W +: GROUP_W]),
            .pend_clr (clr_all[g*GROUP_W +: GROUP_W]),
            .any_evt  (grp_evt[g])
        );
    end

    irq_drain_fsm #(.W(LINES)) u_drain (
        .clk      (clk),
        .rst      (rst),
        .req      (drain_req),
        .set_mask (set_all),
        .clr_mask (clr_all),
        .zero_set (zero_set),
        .zero_clr (zero_clr),
        .valid    (drain_valid),
        .is_set   (drain_is_set),
        .mask_out (drain_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) notify <= 1'b0;
        else     notify <= |grp_evt;
    end
endmodule

module irq_event_collector_chk #(
    parameter int LINES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [LINES-1:0] irq_lines,
    input logic [LINES-1:0] trig_level,
    input logic             notify,
    input logic             drain_valid,
    input logic             drain_is_set
);
    // R2 / R4: any sampled rise leads to a notify pulse
    p_notify_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ((irq_lines & ~$past(irq_lines)) != '0)) |=> notify);

    // R5 / R10: without a rise or a level-mode fall, no pulse
    p_quiet_edge_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ((irq_lines & ~$past(irq_lines)) == '0)
         && ((~irq_lines & $past(irq_lines) & trig_level) == '0)) |=> !notify);

    // R6: the lowering mask is always followed by the raising mask
    p_clear_then_set_r6: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && !drain_is_set) |=> (drain_valid && drain_is_set));

    // R6: the raising mask only appears right after the lowering mask
    p_set_follows_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && drain_is_set) |-> $past(drain_valid && !drain_is_set));

    // R8: the cycle after reset is quiet
    p_reset_quiet_r8: assert property (@(posedge clk)
        $past(rst) |-> (!notify && !drain_valid));
endmodule

bind irq_event_collector irq_event_collector_chk #(.LINES(LINES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_lines    (irq_lines),
    .trig_level   (trig_level),
    .notify       (notify),
    .drain_valid  (drain_valid),
    .drain_is_set (drain_is_set)
);

// File: tb/irq_event_collector_test.sv
module irq_event_collector_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] irq_lines;
    logic [15:0] trig_level;
    logic        drain_req;
    logic        notify;
    logic        drain_valid;
    logic        drain_is_set;
    logic [15:0] drain_mask;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] got_clr;
    logic [15:0] got_set;

    always #10 clk = ~clk;

    irq_event_collector uut (
        .clk          (clk),
        .rst          (rst),
        .irq_lines    (irq_lines),
        .trig_level   (trig_level),
        .drain_req    (drain_req),
        .notify       (notify),
        .drain_valid  (drain_valid),
        .drain_is_set (drain_is_set),
        .drain_mask   (drain_mask)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Drain both masks; checks ordering flags (R6)
    task automatic drain_both();
        drain_req = 1'b1;
        tick();
        drain_req = 1'b0;
        chk("R6 clr phase valid/kind", {14'd0, drain_valid, drain_is_set}, 16'h0002);
        got_clr = drain_mask;
        tick();
        chk("R6 set phase valid/kind", {14'd0, drain_valid, drain_is_set}, 16'h0003);
        got_set = drain_mask;
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; irq_lines = '0; trig_level = '0; drain_req = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R8 notify after reset", {15'd0, notify}, 16'h0000);
        chk("R8 valid after reset", {15'd0, drain_valid}, 16'h0000);
        drain_both();
        chk("R8 clr mask zero", got_clr, 16'h0000);
        chk("R8 set mask zero", got_set, 16'h0000);
    endtask

    task automatic t_level();
        trig_level = 16'h0100;
        irq_lines[8] = 1'b1;
        tick();
        chk("R2 notify on level rise", {15'd0, notify}, 16'h0001);
        tick();
        chk("R10 notify one cycle", {15'd0, notify}, 16'h0000);
        drain_both();
        chk("R2 clr mask", got_clr, 16'h0000);
        chk("R7 secondary line 0 at bit 8", got_set, 16'h0100);
        irq_lines[8] = 1'b0;
        tick();
        chk("R3 notify on level fall", {15'd0, notify}, 16'h0001);
        drain_both();
        chk("R3 clr mask", got_clr, 16'h0100);
        chk("R3 set mask", got_set, 16'h0000);
        // rise then fall without drain: the raising bit is cancelled
        irq_lines[8] = 1'b1; tick();
        irq_lines[8] = 1'b0; tick();
        drain_both();
        chk("R3 cancel set clr", got_clr, 16'h0100);
        chk("R3 cancel set set", got_set, 16'h0000);
        // fall then rise without drain: the lowering bit is cancelled
        irq_lines[8] = 1'b1; tick();
        drain_both();
        irq_lines[8] = 1'b0; tick();
        irq_lines[8] = 1'b1; tick();
        drain_both();
        chk("R2 cancel clr clr", got_clr, 16'h0000);
        chk("R2 cancel clr set", got_set, 16'h0100);
        irq_lines[8] = 1'b0; tick();
        drain_both();
    endtask

    task automatic t_edge();
        trig_level = 16'h0000;
        irq_lines[3] = 1'b1;
        tick();
        chk("R4 notify on edge rise", {15'd0, notify}, 16'h0001);
        tick(); tick();
        chk("R4 held line no notify", {15'd0, notify}, 16'h0000);
        drain_both();
        chk("R4 clr mask", got_clr, 16'h0000);
        chk("R4 set mask", got_set, 16'h0008);
        tick();
        drain_both();
        chk("R4 held line not re-recorded", got_set, 16'h0000);
        irq_lines[3] = 1'b0;
        tick();
        chk("R5 no notify on edge fall", {15'd0, notify}, 16'h0000);
        drain_both();
        chk("R5 clr mask after fall", got_clr, 16'h0000);
        chk("R5 set mask after fall", got_set, 16'h0000);
        irq_lines[3] = 1'b1;
        tick();
        chk("R5 rearmed edge notify", {15'd0, notify}, 16'h0001);
        irq_lines[3] = 1'b0;
        drain_both();
        chk("R5 rearmed edge set", got_set, 16'h0008);
    endtask

    task automatic t_multi();
        trig_level = 16'h0000;
        irq_lines[0] = 1'b1; irq_lines[15] = 1'b1;
        tick();
        chk("R10 single pulse high", {15'd0, notify}, 16'h0001);
        tick();
        chk("R10 single pulse low", {15'd0, notify}, 16'h0000);
        drain_both();
        chk("R7 primary 0 and secondary 7", got_set, 16'h8001);
        irq_lines = '0; tick();
    endtask

    task automatic t_mixed();
        trig_level = 16'h00F0;
        irq_lines = 16'h0011;
        tick();
        drain_both();
        chk("R1 mixed rise set", got_set, 16'h0011);
        irq_lines = 16'h0000;
        tick();
        chk("R1 level fall notifies", {15'd0, notify}, 16'h0001);
        drain_both();
        chk("R1 only level line lowered", got_clr, 16'h0010);
        chk("R1 set after falls", got_set, 16'h0000);
    endtask

    task automatic t_collision();
        trig_level = 16'h0000;
        irq_lines = 16'h0000;
        irq_lines[1] = 1'b1;
        tick();
        drain_req = 1'b1;
        tick();
        drain_req = 1'b0;
        tick();
        chk("R9 first drain set", drain_mask, 16'h0002);
        irq_lines[9] = 1'b1; // sampled at the edge that zeroes the raising mask
        tick();
        drain_both();
        chk("R9 event survives zeroing", got_set, 16'h0200);
        irq_lines = '0; tick();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_level();
        t_edge();
        t_multi();
        t_mixed();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule